// File: doc/BRIEF.md
# Register Scoreboard Wakeup Unit

This block keeps one ready bit for each physical register and records which consumer slots are waiting on each register that is not ready. A dispatch names a consumer slot, up to two source registers and an optional destination register. Allocating the destination clears that register's ready bit. Each source that is still not ready after a recheck against the scoreboard adds the slot as a waiter on that register.

A completion names a produced register. The unit sets the register's ready bit and clears the pending operand in every waiting slot. Any slot whose operands are then all ready is reported on a one-cycle pulse vector. The issue selection logic that consumes this vector sits outside the block.

Waiters are stored as a bit vector over the slots for each register. A squash therefore only has to clear the bits for the operands the slot was still waiting on. Register indices at or above the physical range are not tracked.

Top module: `reg_wakeup_unit`

## Requirements
- R1: Dispatching with a tracked destination register clears its ready bit, so a later consumer naming that register as a source waits until the register completes.
- R2: If a tracked destination is allocated while its waiter vector is not empty, `alloc_err_o` pulses high one cycle later. A waiter vector emptied by a completion of the same register in the same cycle does not count.
- R3: A source whose incoming ready flag is 0 is rechecked against the scoreboard. If the scoreboard shows the register ready, the operand counts as ready and no waiter is recorded.
- R4: Indices with value ≥ NUM_PREGS (the default is 64, and the index is 7 bits wide) are untracked. As sources they never block. As destinations they clear nothing. As completions they wake no slot.
- R5: A completion of a tracked register sets its ready bit and clears the matching pending operand of every waiting slot. It then empties that register's waiter vector, so a repeat completion wakes nothing.
- R6: `issue_ready_o[s]` pulses for one cycle, one cycle after the event, only when slot s has no pending operand left. This happens either at dispatch with all sources ready, or at the wakeup that clears its last pending operand.
- R7: A squash of slot s removes s only from the waiter vectors of operands it was still pending on. Slot s never pulses ready afterwards, and reallocating such a register raises no error.
- R8: After reset every physical register is ready, every waiter vector is empty and both outputs are 0.
- R9: A dispatch source that names the register completing in the same cycle counts as ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_valid_i | input | 1 | Dispatch of a consumer this cycle |
| disp_slot_i | input | SLOT_W | Consumer slot being filled |
| disp_src_i | input | NSRC*IDX_W | Source indices; source k sits at bits k*IDX_W upward |
| disp_src_rdy_i | input | NSRC | Incoming per-source ready flags |
| disp_dst_valid_i | input | 1 | The dispatch allocates a destination |
| disp_dst_i | input | IDX_W | Destination register index |
| done_valid_i | input | 1 | A producer completes |
| done_reg_i | input | IDX_W | Register written by the completing producer |
| kill_valid_i | input | 1 | Squash a consumer slot |
| kill_slot_i | input | SLOT_W | Slot to squash (never the slot being dispatched) |
| issue_ready_o | output | NUM_SLOTS | One-cycle pulse per slot whose operands became all ready |
| alloc_err_o | output | 1 | Destination allocated while it still had waiters |

## Verification
Both outputs are registered, so the ready pulse and the error flag for any dispatch, completion or squash are due exactly one clock edge after the cycle in which that stimulus is presented. The driver applies each stimulus on a falling edge and queues the expected pulse vector and error bit for it. The monitor pops one entry per rising edge and samples 1 ns after that edge, so each result is compared in the cycle it belongs to. Effects with no direct output, such as a cleared ready bit, a dropped waiter or an untracked index that must change nothing, are exposed by a follow-up dispatch or allocation whose pulse or error bit depends on them.

// File: rtl/sbw_pkg.sv
package sbw_pkg;
  // number of source operands per consumer
  localparam int unsigned SBW_NSRC = 2;
endpackage

// File: rtl/sbw_ready_bits.sv
module sbw_ready_bits #(
  parameter int NUM_PREGS = 64,
  parameter int PREG_W    = 6,
  parameter int NRD       = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       set_en,
  input  logic [PREG_W-1:0]          set_row,
  input  logic                       clr_en,
  input  logic [PREG_W-1:0]          clr_row,
  input  logic [NRD-1:0][PREG_W-1:0] rd_row,
  output logic [NRD-1:0]             rd_ready,
  output logic [NUM_PREGS-1:0]       ready_all
);
  logic [NUM_PREGS-1:0] bits_q;

  // allocation is written last so it overrides a same-register completion
  always_ff @(posedge clk) begin
    if (rst) begin
      bits_q <= '1;
    end else begin
      if (set_en) bits_q[set_row] <= 1'b1;
      if (clr_en) bits_q[clr_row] <= 1'b0;
    end
  end

  for (genvar k = 0; k < NRD; k++) begin : g_rd
    assign rd_ready[k] = bits_q[rd_row[k]];
  end

  assign ready_all = bits_q;
endmodule

// File: rtl/sbw_waiter_matrix.sv
module sbw_waiter_matrix #(
  parameter int NUM_PREGS = 64,
  parameter int NUM_SLOTS = 16,
  parameter int PREG_W    = 6,
  parameter int SLOT_W    = 4,
  parameter int NPORT     = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wipe_en,
  input  logic [PREG_W-1:0]            wipe_row,
  input  logic [NPORT-1:0]             add_en,
  input  logic [NPORT-1:0][PREG_W-1:0] add_row,
  input  logic [SLOT_W-1:0]            add_slot,
  input  logic [NPORT-1:0]             drop_en,
  input  logic [NPORT-1:0][PREG_W-1:0] drop_row,
  input  logic [SLOT_W-1:0]            drop_slot,
  input  logic [PREG_W-1:0]            chk_row,
  output logic [NUM_SLOTS-1:0]         wake_vec,
  output logic                         chk_busy
);
  logic [NUM_PREGS-1:0][NUM_SLOTS-1:0] wq, wn;

  always_comb begin
    wn = wq;
    if (wipe_en) wn[wipe_row] = '0;
    for (int k = 0; k < NPORT; k++)
      if (drop_en[k]) wn[drop_row[k]][drop_slot] = 1'b0;
    for (int k = 0; k < NPORT; k++)
      if (add_en[k]) wn[add_row[k]][add_slot] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) wq <= '0;
    else     wq <= wn;
  end

  assign wake_vec = wq[wipe_row];
  assign chk_busy = |wq[chk_row];
endmodule

// File: rtl/sbw_slot_track.sv
module sbw_slot_track #(
  parameter int NUM_SLOTS = 16,
  parameter int SLOT_W    = 4,
  parameter int PREG_W    = 6,
  parameter int NSRC      = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        ld_en,
  input  logic [SLOT_W-1:0]           ld_slot,
  input  logic [NSRC-1:0]             ld_pend,
  input  logic [NSRC-1:0][PREG_W-1:0] ld_row,
  input  logic                        wk_en,
  input  logic [PREG_W-1:0]           wk_row,
  input  logic [NUM_SLOTS-1:0]        wk_vec,
  input  logic                        kl_en,
  input  logic [SLOT_W-1:0]           kl_slot,
  output logic [NSRC-1:0]             kl_pend,
  output logic [NSRC-1:0][PREG_W-1:0] kl_row,
  output logic [NUM_SLOTS-1:0]        ready_o
);
  logic [NUM_SLOTS-1:0]                   live_q, live_n, fire;
  logic [NUM_SLOTS-1:0][NSRC-1:0]         pend_q, pend_n;
  logic [NUM_SLOTS-1:0][NSRC-1:0][PREG_W-1:0] row_q;

  always_comb begin
    live_n = live_q;
    pend_n = pend_q;
    fire   = '0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      if (wk_en && wk_vec[s] && live_q[s]) begin
        for (int k = 0; k < NSRC; k++)
          if (row_q[s][k] == wk_row) pend_n[s][k] = 1'b0;
        fire[s] = (pend_q[s] != '0) && (pend_n[s] == '0);
      end
      if (ld_en && ld_slot == SLOT_W'(s)) begin
        live_n[s] = 1'b1;
        pend_n[s] = ld_pend;
        fire[s]   = (ld_pend == '0);
      end
      if (kl_en && kl_slot == SLOT_W'(s)) begin
        live_n[s] = 1'b0;
        pend_n[s] = '0;
        fire[s]   = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      live_q  <= '0;
      pend_q  <= '0;
      row_q   <= '0;
      ready_o <= '0;
    end else begin
      live_q  <= live_n;
      pend_q  <= pend_n;
      ready_o <= fire;
      if (ld_en) row_q[ld_slot] <= ld_row;
    end
  end

  assign kl_pend = pend_q[kl_slot];
  assign kl_row  = row_q[kl_slot];
endmodule

// File: rtl/reg_wakeup_unit.sv
module reg_wakeup_unit
  import sbw_pkg::*;
#(
  parameter int NUM_PREGS = 64,
  parameter int NUM_SLOTS = 16,
  parameter int IDX_W     = 7,
  localparam int PREG_W   = $clog2(NUM_PREGS),
  localparam int SLOT_W   = $clog2(NUM_SLOTS),
  localparam int NSRC     = SBW_NSRC
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  disp_valid_i,
  input  logic [SLOT_W-1:0]     disp_slot_i,
  input  logic [NSRC*IDX_W-1:0] disp_src_i,
  input  logic [NSRC-1:0]       disp_src_rdy_i,
  input  logic                  disp_dst_valid_i,
  input  logic [IDX_W-1:0]      disp_dst_i,
  input  logic                  done_valid_i,
  input  logic [IDX_W-1:0]      done_reg_i,
  input  logic                  kill_valid_i,
  input  logic [SLOT_W-1:0]     kill_slot_i,
  output logic [NUM_SLOTS-1:0]  issue_ready_o,
  output logic                  alloc_err_o
);
  logic                        done_trk;
  logic [PREG_W-1:0]           done_row;
  logic                        dst_alloc;
  logic [PREG_W-1:0]           dst_row;
  logic [NSRC-1:0][PREG_W-1:0] src_row;
  logic [NSRC-1:0]             src_sb, src_wait;
  logic [NSRC-1:0]             kl_pend;
  logic [NSRC-1:0][PREG_W-1:0] kl_row;
  logic [NUM_SLOTS-1:0]        wake_vec;
  logic                        dst_busy;
  logic [NUM_PREGS-1:0]        sb_vec;

  assign done_trk  = done_valid_i && (int'(done_reg_i) < NUM_PREGS);
  assign done_row  = done_reg_i[PREG_W-1:0];
  assign dst_alloc = disp_valid_i && disp_dst_valid_i && (int'(disp_dst_i) < NUM_PREGS);
  assign dst_row   = disp_dst_i[PREG_W-1:0];

  // per source: tracking range, scoreboard recheck and completion bypass
  for (genvar k = 0; k < NSRC; k++) begin : g_src
    logic [IDX_W-1:0] idx;
    logic             trk, byp;
    assign idx         = disp_src_i[k*IDX_W +: IDX_W];
    assign trk         = int'(idx) < NUM_PREGS;
    assign src_row[k]  = idx[PREG_W-1:0];
    assign byp         = done_trk && (done_row == src_row[k]);
    assign src_wait[k] = disp_valid_i && trk && !disp_src_rdy_i[k] && !src_sb[k] && !byp;
  end

  sbw_ready_bits #(.NUM_PREGS(NUM_PREGS), .PREG_W(PREG_W), .NRD(NSRC)) u_ready (
    .clk(clk), .rst(rst),
    .set_en(done_trk), .set_row(done_row),
    .clr_en(dst_alloc), .clr_row(dst_row),
    .rd_row(src_row), .rd_ready(src_sb),
    .ready_all(sb_vec)
  );

  sbw_waiter_matrix #(.NUM_PREGS(NUM_PREGS), .NUM_SLOTS(NUM_SLOTS), .PREG_W(PREG_W),
                      .SLOT_W(SLOT_W), .NPORT(NSRC)) u_wait (
    .clk(clk), .rst(rst),
    .wipe_en(done_trk), .wipe_row(done_row),
    .add_en(src_wait), .add_row(src_row), .add_slot(disp_slot_i),
    .drop_en(kl_pend & {NSRC{kill_valid_i}}), .drop_row(kl_row), .drop_slot(kill_slot_i),
    .chk_row(dst_row),
    .wake_vec(wake_vec), .chk_busy(dst_busy)
  );

  sbw_slot_track #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W), .PREG_W(PREG_W), .NSRC(NSRC)) u_slots (
    .clk(clk), .rst(rst),
    .ld_en(disp_valid_i), .ld_slot(disp_slot_i), .ld_pend(src_wait), .ld_row(src_row),
    .wk_en(done_trk), .wk_row(done_row), .wk_vec(wake_vec),
    .kl_en(kill_valid_i), .kl_slot(kill_slot_i), .kl_pend(kl_pend), .kl_row(kl_row),
    .ready_o(issue_ready_o)
  );

  always_ff @(posedge clk) begin
    if (rst) alloc_err_o <= 1'b0;
    else     alloc_err_o <= dst_alloc && dst_busy && !(done_trk && done_row == dst_row);
  end
endmodule

// File: rtl/sbw_checker.sv
module sbw_checker #(
  parameter int NUM_PREGS = 64,
  parameter int NUM_SLOTS = 16,
  parameter int IDX_W     = 7,
  parameter int PREG_W    = 6,
  parameter int SLOT_W    = 4,
  parameter int NSRC      = 2
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  disp_valid_i,
  input logic [SLOT_W-1:0]     disp_slot_i,
  input logic [NSRC*IDX_W-1:0] disp_src_i,
  input logic [NSRC-1:0]       disp_src_rdy_i,
  input logic                  disp_dst_valid_i,
  input logic [IDX_W-1:0]      disp_dst_i,
  input logic                  done_valid_i,
  input logic [IDX_W-1:0]      done_reg_i,
  input logic                  kill_valid_i,
  input logic [SLOT_W-1:0]     kill_slot_i,
  input logic [NUM_SLOTS-1:0]  issue_ready_o,
  input logic                  alloc_err_o,
  input logic [NUM_PREGS-1:0]  sb_vec
);
  logic [NSRC-1:0] untr, on_done;
  logic            dst_trk, done_trk;
  assign dst_trk  = disp_dst_valid_i && (int'(disp_dst_i) < NUM_PREGS);
  assign done_trk = done_valid_i && (int'(done_reg_i) < NUM_PREGS);
  for (genvar k = 0; k < NSRC; k++) begin : g_s
    assign untr[k]    = int'(disp_src_i[k*IDX_W +: IDX_W]) >= NUM_PREGS;
    assign on_done[k] = untr[k] || (done_trk && disp_src_i[k*IDX_W +: IDX_W] == done_reg_i);
  end

  AST_ALLOC_CLEARS: assert property (@(posedge clk) disable iff (rst)
    disp_valid_i && dst_trk |=> !sb_vec[$past(disp_dst_i[PREG_W-1:0])]); // R1
  AST_ERR_NEEDS_ALLOC: assert property (@(posedge clk) disable iff (rst)
    alloc_err_o |-> $past(disp_valid_i && disp_dst_valid_i)); // R2
  AST_UNTRACKED_FREE: assert property (@(posedge clk) disable iff (rst)
    disp_valid_i && !kill_valid_i && (&untr) |=> issue_ready_o[$past(disp_slot_i)]); // R4
  AST_DONE_SETS: assert property (@(posedge clk) disable iff (rst)
    done_trk && !(disp_valid_i && dst_trk && disp_dst_i == done_reg_i)
    |=> sb_vec[$past(done_reg_i[PREG_W-1:0])]); // R5
  AST_KILL_SILENT: assert property (@(posedge clk) disable iff (rst)
    kill_valid_i |=> !issue_ready_o[$past(kill_slot_i)]); // R7
  AST_RESET_READY: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (&sb_vec) && (issue_ready_o == '0) && !alloc_err_o); // R8
  AST_BYPASS_READY: assert property (@(posedge clk) disable iff (rst)
    disp_valid_i && !kill_valid_i && (&on_done) |=> issue_ready_o[$past(disp_slot_i)]); // R9
endmodule

bind reg_wakeup_unit sbw_checker #(
  .NUM_PREGS(NUM_PREGS), .NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W),
  .PREG_W(PREG_W), .SLOT_W(SLOT_W), .NSRC(NSRC)
) u_chk (
  .clk(clk), .rst(rst), .disp_valid_i(disp_valid_i), .disp_slot_i(disp_slot_i),
  .disp_src_i(disp_src_i), .disp_src_rdy_i(disp_src_rdy_i),
  .disp_dst_valid_i(disp_dst_valid_i), .disp_dst_i(disp_dst_i),
  .done_valid_i(done_valid_i), .done_reg_i(done_reg_i),
  .kill_valid_i(kill_valid_i), .kill_slot_i(kill_slot_i),
  .issue_ready_o(issue_ready_o), .alloc_err_o(alloc_err_o), .sb_vec(sb_vec)
);

// File: tb/reg_wakeup_unit_tb.sv
module reg_wakeup_unit_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        disp_valid_i, disp_dst_valid_i, done_valid_i, kill_valid_i;
  logic [3:0]  disp_slot_i, kill_slot_i;
  logic [13:0] disp_src_i;
  logic [1:0]  disp_src_rdy_i;
  logic [6:0]  disp_dst_i, done_reg_i;
  logic [15:0] issue_ready_o;
  logic        alloc_err_o;

  typedef struct { logic [15:0] rdy; logic err; string tag; } exp_t;
  exp_t exp_q[$];
  int checks = 0, fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  reg_wakeup_unit u_dut (
    .clk(clk), .rst(rst), .disp_valid_i(disp_valid_i), .disp_slot_i(disp_slot_i),
    .disp_src_i(disp_src_i), .disp_src_rdy_i(disp_src_rdy_i),
    .disp_dst_valid_i(disp_dst_valid_i), .disp_dst_i(disp_dst_i),
    .done_valid_i(done_valid_i), .done_reg_i(done_reg_i),
    .kill_valid_i(kill_valid_i), .kill_slot_i(kill_slot_i),
    .issue_ready_o(issue_ready_o), .alloc_err_o(alloc_err_o)
  );

  // monitor: each queued item is due one edge after it was driven
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      checks++;
      if (issue_ready_o !== e.rdy || alloc_err_o !== e.err) begin
        fails++;
        $display("FAIL %s: ready=%h err=%b expected ready=%h err=%b",
                 e.tag, issue_ready_o, alloc_err_o, e.rdy, e.err);
      end
    end
  end

  task automatic step(input bit dv, input int sl, input int s0, input bit r0,
                      input int s1, input bit r1, input bit dstv, input int dst,
                      input bit cv, input int cr, input bit kv, input int ks,
                      input logic [15:0] er, input bit ee, input string tag);
    @(negedge clk);
    disp_valid_i = dv; disp_slot_i = 4'(sl);
    disp_src_i = {7'(s1), 7'(s0)}; disp_src_rdy_i = {r1, r0};
    disp_dst_valid_i = dstv; disp_dst_i = 7'(dst);
    done_valid_i = cv; done_reg_i = 7'(cr);
    kill_valid_i = kv; kill_slot_i = 4'(ks);
    exp_q.push_back('{er, ee, tag});
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    rst = 1'b1;
    disp_valid_i = 0; disp_slot_i = 0; disp_src_i = 0; disp_src_rdy_i = 0;
    disp_dst_valid_i = 0; disp_dst_i = 0; done_valid_i = 0; done_reg_i = 0;
    kill_valid_i = 0; kill_slot_i = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (issue_ready_o !== 16'h0 || alloc_err_o !== 1'b0) begin
      fails++;
      $display("FAIL R8 reset outputs: ready=%h err=%b expected ready=0000 err=0",
               issue_ready_o, alloc_err_o);
    end
    rst = 1'b0;
    //   dv sl  s0 r0  s1 r1 dv dst cv cr kv ks  exp      err
    step(1, 0,  10,0,  11,0, 0, 0,  0, 0, 0, 0, 16'h0001, 0, "R8 R3 reset-ready sources");
    step(1, 1, 100,0, 100,0, 1, 20, 0, 0, 0, 0, 16'h0002, 0, "R4 untracked sources");
    step(1, 2,  20,0,  21,1, 0, 0,  0, 0, 0, 0, 16'h0000, 0, "R1 allocated source waits");
    step(1, 4, 100,0, 100,0, 1, 23, 0, 0, 0, 0, 16'h0010, 0, "R6 all-ready dispatch");
    step(1, 3,  20,0,  23,0, 0, 0,  0, 0, 0, 0, 16'h0000, 0, "R1 two pending sources");
    step(0, 0,   0,0,   0,0, 0, 0,  1, 20,0, 0, 16'h0004, 0, "R5 R6 wake on completion");
    step(0, 0,   0,0,   0,0, 0, 0,  1, 20,0, 0, 16'h0000, 0, "R5 waiter list cleared");
    step(0, 0,   0,0,   0,0, 0, 0,  1,100,0, 0, 16'h0000, 0, "R4 untracked completion");
    step(0, 0,   0,0,   0,0, 0, 0,  1, 23,0, 0, 16'h0008, 0, "R6 last operand ready");
    step(1, 5, 100,0, 100,0, 1, 30, 0, 0, 0, 0, 16'h0020, 0, "R1 alloc 30");
    step(1, 6,  30,0, 100,0, 0, 0,  0, 0, 0, 0, 16'h0000, 0, "R1 waiter on 30");
    step(1, 7, 100,0, 100,0, 1, 30, 0, 0, 0, 0, 16'h0080, 1, "R2 alloc with waiters");
    step(0, 0,   0,0,   0,0, 0, 0,  1, 30,0, 0, 16'h0040, 0, "R5 wake after error");
    step(1, 8, 100,0, 100,0, 1, 40, 0, 0, 0, 0, 16'h0100, 0, "R1 alloc 40");
    step(1, 9,  40,0, 100,0, 0, 0,  1, 40,0, 0, 16'h0200, 0, "R9 same-cycle bypass");
    step(1,10, 100,0, 100,0, 1, 50, 0, 0, 0, 0, 16'h0400, 0, "R1 alloc 50");
    step(1,11,  50,0,  51,1, 0, 0,  0, 0, 0, 0, 16'h0000, 0, "R1 waiter on 50");
    step(0, 0,   0,0,   0,0, 0, 0,  0, 0, 1, 11, 16'h0000, 0, "R7 squash");
    step(1,12, 100,0, 100,0, 1, 50, 0, 0, 0, 0, 16'h1000, 0, "R7 waiter dropped");
    step(0, 0,   0,0,   0,0, 0, 0,  1, 50,0, 0, 16'h0000, 0, "R7 squashed slot silent");
    step(1,14, 100,0, 100,0, 1, 10, 0, 0, 0, 0, 16'h4000, 0, "R3 no waiter recorded");
    step(1,15, 100,0, 100,0, 1,100, 0, 0, 0, 0, 16'h8000, 0, "R4 untracked destination");
    step(1,13,  36,0, 100,0, 0, 0,  0, 0, 0, 0, 16'h2000, 0, "R4 alias register untouched");
    step(0, 0,   0,0,   0,0, 0, 0,  0, 0, 0, 0, 16'h0000, 0, "R6 idle no pulse");
    repeat (3) @(posedge clk);
    #2;
    finish_run();
  end
endmodule